// File: doc/BRIEF.md
# SPI Dual-Mode Data Buffer

This block sits between a register interface and an SPI shift engine and holds the data in both directions. Each direction has 32 bits of storage. One mode input sets how both stores behave. In word mode each store holds one 32-bit word. In FIFO mode each store is a queue of four byte-wide entries, served in first-in first-out order.

On the register side, a write strobe loads the transmit store and a read strobe drains the receive store. On the engine side, the shifter is offered the oldest transmit item and takes it with a strobe. Received items are pushed in with a second strobe.

The block keeps three flags:
- receive-not-empty;
- transmit-drained, meaning the transmit store has fully emptied;
- a sticky transmit-overflow bit.

The first two flags, gated by an interrupt enable, drive a single interrupt request line.

Top module: `spi_dual_buf`

## Requirements
- R1: Word mode (`mode_fifo`=0). An accepted TXD write loads all 32 bits. The store then shows `sh_tx_valid`=1 with that word on `sh_tx_data` until `sh_tx_take` empties it. A pushed receive word appears whole on `rxd_rdata`, and one `rxd_rd` empties the store.
- R2: FIFO mode (`mode_fifo`=1). Each accepted TXD write queues `txd_wdata[7:0]`, up to four entries. `sh_tx_data` shows the oldest byte zero-extended in bits 7:0, and each take removes one byte in write order.
- R3: FIFO mode, receive side. Each shifter push queues `sh_rx_data[7:0]`, up to four entries. `rxd_rdata` shows the oldest byte zero-extended, and each read removes one byte in arrival order.
- R4: A TXD write while the transmit store is full is ignored. Full means four bytes in FIFO mode or one word in word mode, with no take in the same cycle. The write sets `tx_ovf`, which stays 1 until reset.
- R5: While the receive store is empty, `rxd_rdata` reads 0 and `rxd_rd` changes no state.
- R6: `rx_nempty` becomes 1 in the cycle after an accepted receive push. It returns to 0 in the cycle after the read that leaves the receive store empty.
- R7: `tx_drained` is 0 after reset. It becomes 1 in the cycle after the shifter takes the last transmit item with no write accepted in that cycle. It returns to 0 in the cycle after the next accepted TXD write.
- R8: `irq` is 1 exactly when `irq_en` is 1 and at least one of `rx_nempty` and `tx_drained` is 1.
- R9: In any cycle where `mode_fifo` differs from the mode in use, both stores are emptied and both flags are cleared, starting the next cycle. All reads, writes, takes and pushes in that cycle are ignored.
- R10: A receive read and a shifter push in the same cycle are both honoured, and the fill level is unchanged. The same holds for a TXD write and a take on a full transmit store.
- R11: A shifter push into a full receive store with no read in the same cycle is dropped, and the stored data is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_fifo | input | 1 | 0 = word mode, 1 = four-byte FIFO mode |
| irq_en | input | 1 | Interrupt enable |
| txd_wr | input | 1 | TXD write strobe |
| txd_wdata | input | 32 | TXD write data |
| rxd_rd | input | 1 | RXD read strobe |
| rxd_rdata | output | 32 | Oldest receive item, zero when empty |
| sh_tx_valid | output | 1 | Transmit store holds an item |
| sh_tx_data | output | 32 | Oldest transmit item |
| sh_tx_take | input | 1 | Shifter consumes the offered item |
| sh_rx_push | input | 1 | Shifter delivers a received item |
| sh_rx_data | input | 32 | Received item |
| rx_nempty | output | 1 | Receive-not-empty flag |
| tx_drained | output | 1 | Transmit-fully-drained flag |
| tx_ovf | output | 1 | Sticky transmit overflow |
| irq | output | 1 | Interrupt request |

## Verification
A corrupted read or write pointer shows up on `sh_tx_data` or `rxd_rdata` as a byte out of order. A wrong fill count shows up as one of the following:
- `sh_tx_valid` or `rx_nempty` disagreeing with the number of items queued;
- a fifth write being accepted;
- a read returning stale data instead of zero.

The bench compares every output with its own queue model on every cycle. Any such fault is therefore reported in the first cycle it reaches a port, which is at most one clock after the faulty update. A flush or flag fault shows one cycle after the mode change or the draining take.

// File: rtl/spi_dual_buf_pkg.sv
package spi_dual_buf_pkg;
    localparam int SDB_LANES  = 4;
    localparam int SDB_LANE_W = 8;

    typedef enum logic {
        SDB_MODE_WORD = 1'b0,
        SDB_MODE_FIFO = 1'b1
    } sdb_mode_e;
endpackage

// File: rtl/sdb_store.sv
module sdb_store #(
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             flush,
    input  logic                             word_mode,
    input  logic                             push,
    input  logic [LANES*LANE_W-1:0]          push_data,
    input  logic                             pop,
    output logic [LANES*LANE_W-1:0]          head,
    output logic [$clog2(LANES+1)-1:0]       level,
    output logic                             push_ok,
    output logic                             pop_ok
);
    localparam int WORD_W = LANES * LANE_W;
    localparam int CNT_W  = $clog2(LANES + 1);
    localparam int PTR_W  = (LANES > 1) ? $clog2(LANES) : 1;

    typedef struct packed {
        logic [LANES-1:0][LANE_W-1:0] mem;
        logic [PTR_W-1:0]             rptr;
        logic [PTR_W-1:0]             wptr;
        logic [CNT_W-1:0]             cnt;
    } store_t;

    store_t st_d, st_q;
    logic   full;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(LANES - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        full    = (st_q.cnt == CNT_W'(LANES));
        pop_ok  = pop && !flush && (st_q.cnt != '0);
        push_ok = push && !flush && (!full || pop_ok);
        st_d    = st_q;
        if (flush) begin
            st_d.cnt  = '0;
            st_d.rptr = '0;
            st_d.wptr = '0;
        end else if (word_mode) begin
            if (push_ok) begin
                st_d.mem  = push_data;
                st_d.cnt  = CNT_W'(LANES);
                st_d.rptr = '0;
                st_d.wptr = '0;
            end else if (pop_ok) begin
                st_d.cnt = '0;
            end
        end else begin
            if (pop_ok) begin
                st_d.rptr = ptr_inc(st_q.rptr);
            end
            if (push_ok) begin
                st_d.mem[st_q.wptr] = push_data[LANE_W-1:0];
                st_d.wptr           = ptr_inc(st_q.wptr);
            end
            if (push_ok && !pop_ok) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end else if (pop_ok && !push_ok) begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end

        head = '0;
        if (st_q.cnt != '0) begin
            if (word_mode) begin
                head = st_q.mem;
            end else begin
                head[LANE_W-1:0] = st_q.mem[st_q.rptr];
            end
        end
        level = st_q.cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(LANES)); // R2
    AST_WORD_ALL_OR_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        word_mode |-> (st_q.cnt == '0 || st_q.cnt == CNT_W'(LANES))); // R1
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (level == '0)); // R9
    AST_PUSHPOP_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (push_ok && pop_ok) |=> $stable(level)); // R10
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !flush && !pop && level == CNT_W'(LANES)) |=> $stable(st_q.mem)); // R11

    logic unused_width;
    assign unused_width = ^WORD_W;
endmodule

// File: rtl/sdb_flags.sv
module sdb_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic irq_en,
    input  logic tx_push_ok,
    input  logic tx_pop_ok,
    input  logic tx_last,
    input  logic tx_wr_rej,
    input  logic rx_push_ok,
    input  logic rx_pop_ok,
    input  logic rx_last,
    output logic rx_flag,
    output logic tx_flag,
    output logic ovf,
    output logic irq
);
    typedef struct packed {
        logic rx;
        logic tx;
        logic ovf;
    } flags_t;

    flags_t fl_d, fl_q;

    always_comb begin
        fl_d = fl_q;
        if (flush) begin
            fl_d.rx = 1'b0;
            fl_d.tx = 1'b0;
        end else begin
            if (rx_push_ok) begin
                fl_d.rx = 1'b1;
            end else if (rx_pop_ok && rx_last) begin
                fl_d.rx = 1'b0;
            end
            if (tx_push_ok) begin
                fl_d.tx = 1'b0;
            end else if (tx_pop_ok && tx_last) begin
                fl_d.tx = 1'b1;
            end
        end
        fl_d.ovf = fl_q.ovf | tx_wr_rej;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fl_q <= '0;
        end else begin
            fl_q <= fl_d;
        end
    end

    assign rx_flag = fl_q.rx;
    assign tx_flag = fl_q.tx;
    assign ovf     = fl_q.ovf;
    assign irq     = irq_en && (fl_q.rx || fl_q.tx);

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> irq_en); // R8
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf); // R4
    AST_TX_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_push_ok && !flush) |=> !tx_flag); // R7
endmodule

// File: rtl/spi_dual_buf.sv
module spi_dual_buf
    import spi_dual_buf_pkg::*;
#(
    parameter int LANES  = SDB_LANES,
    parameter int LANE_W = SDB_LANE_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    mode_fifo,
    input  logic                    irq_en,
    input  logic                    txd_wr,
    input  logic [LANES*LANE_W-1:0] txd_wdata,
    input  logic                    rxd_rd,
    output logic [LANES*LANE_W-1:0] rxd_rdata,
    output logic                    sh_tx_valid,
    output logic [LANES*LANE_W-1:0] sh_tx_data,
    input  logic                    sh_tx_take,
    input  logic                    sh_rx_push,
    input  logic [LANES*LANE_W-1:0] sh_rx_data,
    output logic                    rx_nempty,
    output logic                    tx_drained,
    output logic                    tx_ovf,
    output logic                    irq
);
    localparam int CNT_W = $clog2(LANES + 1);

    sdb_mode_e mode_d, mode_q;
    logic flush, word_mode;
    logic tx_push_ok, tx_pop_ok, rx_push_ok, rx_pop_ok;
    logic tx_last, rx_last, tx_wr_rej;
    logic [CNT_W-1:0] tx_level, rx_level;

    always_comb begin
        mode_d    = mode_fifo ? SDB_MODE_FIFO : SDB_MODE_WORD;
        flush     = (mode_d != mode_q);
        word_mode = (mode_q == SDB_MODE_WORD);
        tx_last   = word_mode || (tx_level == CNT_W'(1));
        rx_last   = word_mode || (rx_level == CNT_W'(1));
        tx_wr_rej = txd_wr && !flush && !tx_push_ok;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= SDB_MODE_WORD;
        end else begin
            mode_q <= mode_d;
        end
    end

    sdb_store #(.LANES(LANES), .LANE_W(LANE_W)) u_tx_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .word_mode (word_mode),
        .push      (txd_wr),
        .push_data (txd_wdata),
        .pop       (sh_tx_take),
        .head      (sh_tx_data),
        .level     (tx_level),
        .push_ok   (tx_push_ok),
        .pop_ok    (tx_pop_ok)
    );

    sdb_store #(.LANES(LANES), .LANE_W(LANE_W)) u_rx_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .word_mode (word_mode),
        .push      (sh_rx_push),
        .push_data (sh_rx_data),
        .pop       (rxd_rd),
        .head      (rxd_rdata),
        .level     (rx_level),
        .push_ok   (rx_push_ok),
        .pop_ok    (rx_pop_ok)
    );

    sdb_flags u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .irq_en     (irq_en),
        .tx_push_ok (tx_push_ok),
        .tx_pop_ok  (tx_pop_ok),
        .tx_last    (tx_last),
        .tx_wr_rej  (tx_wr_rej),
        .rx_push_ok (rx_push_ok),
        .rx_pop_ok  (rx_pop_ok),
        .rx_last    (rx_last),
        .rx_flag    (rx_nempty),
        .tx_flag    (tx_drained),
        .ovf        (tx_ovf),
        .irq        (irq)
    );

    assign sh_tx_valid = (tx_level != '0);

    AST_RX_FLAG_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        rx_nempty == (rx_level != '0)); // R6
    AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_level == '0) |-> (rxd_rdata == '0)); // R5
endmodule

// File: tb/spi_dual_buf_bench.sv
module spi_dual_buf_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_fifo = 1'b0, irq_en = 1'b0;
    logic        txd_wr = 1'b0, rxd_rd = 1'b0, sh_tx_take = 1'b0, sh_rx_push = 1'b0;
    logic [31:0] txd_wdata = '0, sh_rx_data = '0;
    logic [31:0] rxd_rdata, sh_tx_data;
    logic        sh_tx_valid, rx_nempty, tx_drained, tx_ovf, irq;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;
    string phase = "reset";

    logic [31:0] tq[$];
    logic [31:0] rq[$];
    logic        m_mode = 1'b0, m_rx = 1'b0, m_tx = 1'b0, m_ovf = 1'b0;

    always #4 clk = ~clk;

    spi_dual_buf u_spi_dual_buf (
        .clk(clk), .rst_n(rst_n), .mode_fifo(mode_fifo), .irq_en(irq_en),
        .txd_wr(txd_wr), .txd_wdata(txd_wdata), .rxd_rd(rxd_rd), .rxd_rdata(rxd_rdata),
        .sh_tx_valid(sh_tx_valid), .sh_tx_data(sh_tx_data), .sh_tx_take(sh_tx_take),
        .sh_rx_push(sh_rx_push), .sh_rx_data(sh_rx_data), .rx_nempty(rx_nempty),
        .tx_drained(tx_drained), .tx_ovf(tx_ovf), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s [%s] actual=%h expected=%h", req, phase, act, exp);
        end
    endtask

    task automatic compare_all();
        logic [31:0] e_tx, e_rx;
        e_tx = (tq.size() > 0) ? tq[0] : 32'h0;
        e_rx = (rq.size() > 0) ? rq[0] : 32'h0;
        check(m_mode ? "R2 tx_valid" : "R1 tx_valid", {31'b0, sh_tx_valid}, {31'b0, tq.size() > 0});
        check(m_mode ? "R2 tx_data" : "R1 tx_data", sh_tx_data, e_tx);
        check(rq.size() == 0 ? "R5 rxd_rdata" : (m_mode ? "R3 rxd_rdata" : "R1 rxd_rdata"),
              rxd_rdata, e_rx);
        check("R6 rx_nempty", {31'b0, rx_nempty}, {31'b0, m_rx});
        check("R7 tx_drained", {31'b0, tx_drained}, {31'b0, m_tx});
        check("R4 tx_ovf", {31'b0, tx_ovf}, {31'b0, m_ovf});
        check("R8 irq", {31'b0, irq}, {31'b0, irq_en && (m_rx || m_tx)});
    endtask

    task automatic model_step();
        int cap;
        bit tpop, tpush, rpop, rpush;
        if (mode_fifo != m_mode) begin
            tq.delete();
            rq.delete();
            m_rx = 1'b0;
            m_tx = 1'b0;
            m_mode = mode_fifo;
            return;
        end
        cap   = m_mode ? 4 : 1;
        tpop  = sh_tx_take && tq.size() > 0;
        tpush = txd_wr && (tq.size() < cap || tpop);
        rpop  = rxd_rd && rq.size() > 0;
        rpush = sh_rx_push && (rq.size() < cap || rpop);
        if (txd_wr && !tpush) m_ovf = 1'b1;
        if (tpush) m_tx = 1'b0;
        else if (tpop && tq.size() == 1) m_tx = 1'b1;
        if (tpop) void'(tq.pop_front());
        if (tpush) tq.push_back(m_mode ? {24'h0, txd_wdata[7:0]} : txd_wdata);
        if (rpop) void'(rq.pop_front());
        if (rpush) rq.push_back(m_mode ? {24'h0, sh_rx_data[7:0]} : sh_rx_data);
        m_rx = (rq.size() > 0);
    endtask

    task automatic cyc(input bit wr, input logic [31:0] wd, input bit rd,
                       input bit take, input bit push, input logic [31:0] pd);
        txd_wr = wr; txd_wdata = wd; rxd_rd = rd;
        sh_tx_take = take; sh_rx_push = push; sh_rx_data = pd;
        #1;
        compare_all();
        @(posedge clk);
        model_step();
        @(negedge clk);
        txd_wr = 0; rxd_rd = 0; sh_tx_take = 0; sh_rx_push = 0;
    endtask

    task automatic idle(); cyc(0, 0, 0, 0, 0, 0); endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        irq_en = 1'b1;
        phase = "reset state R7";
        idle();

        phase = "word mode R1";
        cyc(1, 32'hA5A5_1234, 0, 0, 0, 0);
        idle();
        cyc(0, 0, 0, 1, 0, 0);
        idle();
        phase = "empty read R5";
        cyc(0, 0, 1, 0, 0, 0);
        phase = "word rx R1";
        cyc(0, 0, 0, 0, 1, 32'hDEAD_BEEF);
        cyc(0, 0, 1, 0, 0, 0);
        idle();

        phase = "word overflow R4";
        cyc(1, 32'h1111_2222, 0, 0, 0, 0);
        cyc(1, 32'h3333_4444, 0, 0, 0, 0);
        idle();
        phase = "word write+take R10";
        cyc(1, 32'h5555_6666, 0, 1, 0, 0);
        cyc(0, 0, 0, 1, 0, 0);

        phase = "mode flush R9";
        cyc(0, 0, 0, 0, 1, 32'h0BAD_F00D);
        mode_fifo = 1'b1;
        cyc(1, 32'h77, 1, 1, 1, 32'h99);
        idle();

        phase = "fifo tx order R2";
        for (int i = 0; i < 5; i++) cyc(1, 32'hFFFF_FF00 | i + 8'h40, 0, 0, 0, 0);
        cyc(1, 32'hC3, 0, 1, 0, 0);
        for (int i = 0; i < 4; i++) cyc(0, 0, 0, 1, 0, 0);
        idle();

        phase = "fifo rx order R3";
        for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 1, 32'hABCD_EF10 + i);
        for (int i = 0; i < 4; i++) cyc(0, 0, 1, 0, 0, 0);

        phase = "rx full drop R11";
        for (int i = 0; i < 5; i++) cyc(0, 0, 0, 0, 1, 32'h20 + i);
        phase = "rx read+push R10";
        cyc(0, 0, 1, 0, 1, 32'h5A);
        for (int i = 0; i < 4; i++) cyc(0, 0, 1, 0, 0, 0);

        phase = "irq gate R8";
        cyc(0, 0, 0, 0, 1, 32'h01);
        irq_en = 1'b0;
        idle();
        irq_en = 1'b1;
        idle();

        phase = "flush to word R9";
        cyc(1, 32'h12, 0, 0, 0, 0);
        mode_fifo = 1'b0;
        idle();
        idle();

        phase = "random R1 R2 R3 R10 R11";
        for (int i = 0; i < 800; i++) begin
            if ($urandom_range(0, 39) == 0) mode_fifo = ~mode_fifo;
            if ($urandom_range(0, 15) == 0) irq_en = ~irq_en;
            cyc($urandom_range(0, 2) == 0, $urandom, $urandom_range(0, 2) == 0,
                $urandom_range(0, 2) == 0, $urandom_range(0, 2) == 0, $urandom);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule